// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Unit

This unit tracks which lanes of one warp are live while the warp walks through conditional branches. Every lane of the warp executes the same instruction in lock-step; the unit holds the active-lane mask that gates the register-file and memory writes of each lane. A lane whose mask bit is 0 has its writes suppressed. Each cycle the unit also produces the PC the front end should fetch next.

When a branch arrives, the per-lane condition is split into the lanes that go to the taken target and the lanes that fall through. Lanes outside the current mask take no part in this split. If all live lanes agree, the warp simply follows them and the mask stays as it was. If they disagree, the taken lanes run first, then the fall-through lanes under the complementary subset, and at the reconvergence PC (supplied from outside as the nearest common post-dominator) the mask that existed before the branch comes back. A last-in, first-out stack holds the pending paths, so divergence nested inside one path unwinds in the right order.

Top module: `simt_diverge_unit`

## Requirements
- R1: After reset the active mask is all ones (every lane live), the stack is empty and the overflow flag is 0.
- R2: A branch whose live lanes all agree leaves the mask unchanged and pushes nothing; the next PC is the taken target if they all have condition bit 1, otherwise the fall-through PC.
- R3: A branch whose live lanes disagree drives the next PC to the taken target, and from the following cycle the mask holds only the live lanes whose condition bit is 1; two stack entries are pushed, the lower one carrying the pre-branch mask and the upper one the else path.
- R4: When the current PC equals the reconvergence PC of the top entry and that entry is the else path, it is popped: the next PC is the fall-through PC and from the following cycle the mask holds the live lanes of the branch whose condition bit was 0.
- R5: When the else path reaches the reconvergence PC, the lower entry is popped: the next PC is the reconvergence PC and the mask returns to the value it had before the branch.
- R6: Condition bits of lanes whose mask bit is 0 have no effect on whether a branch is uniform or on its direction.
- R7: Divergent branches inside a path push further entries, and the entries pop in last-in, first-out order, each pop restoring the mask and PC it saved.
- R8: A divergent branch that finds fewer than two free stack entries (default depth 8) sets a sticky overflow flag, leaves the mask and the stack unchanged, and drives the next PC to the taken target.
- R9: In a cycle with neither a branch nor a reconvergence match, the next PC is the current PC plus the instruction step (default 4) and the mask is unchanged.
- R10: A reconvergence match takes precedence over a branch event presented in the same cycle; that branch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A branch instruction is at the current PC |
| br_cond | input | LANES | Per-lane branch condition, 1 means taken |
| br_target | input | PC_W | Taken target PC |
| br_fall | input | PC_W | Fall-through (else) PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| cur_pc | input | PC_W | PC of the instruction now issuing |
| active_mask | output | LANES | Live lanes; a 0 bit suppresses that lane's writes |
| next_pc | output | PC_W | PC to fetch next (combinational) |
| err_overflow | output | 1 | Sticky flag: a divergent branch found the stack too full |

## Verification
The assertions watch on every cycle that the mask never becomes empty, that a uniform branch keeps the mask, that a divergent branch narrows it to the taken live lanes, that the stack pointer moves by exactly two on a split and one on a pop and never passes its depth, and that an overflow holds the mask and sets a flag that stays set. What only the bench scenarios show is the ordering across many cycles: the else path arriving with the right PC and lanes, the pre-branch mask returning at the reconvergence point, nested paths unwinding last-in first-out, masked-off condition bits being ignored, and a reconvergence match overriding a simultaneous branch.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  typedef enum logic [1:0] {
    BR_NONE_TAKEN = 2'd0,
    BR_ALL_TAKEN  = 2'd1,
    BR_SPLIT      = 2'd2
  } br_kind_e;

  // Classify a branch from whether any live lane goes each way.
  function automatic br_kind_e classify(input logic any_taken, input logic any_other);
    if (any_taken && any_other) return BR_SPLIT;
    if (any_taken)              return BR_ALL_TAKEN;
    return BR_NONE_TAKEN;
  endfunction

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] taken,
  output logic [LANES-1:0] other,
  output br_kind_e         kind
);

  // Only live lanes vote (R6).
  function automatic logic [LANES-1:0] live_true(input logic [LANES-1:0] c,
                                                 input logic [LANES-1:0] m);
    return c & m;
  endfunction

  function automatic logic [LANES-1:0] live_false(input logic [LANES-1:0] c,
                                                  input logic [LANES-1:0] m);
    return ~c & m;
  endfunction

  always_comb begin
    taken = live_true(cond, mask);
    other = live_false(cond, mask);
    kind  = classify(|taken, |other);
  end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [PC_W-1:0]  push_rpc,
  input  logic [PC_W-1:0]  push_else_pc,
  input  logic [LANES-1:0] push_else_mask,
  input  logic [LANES-1:0] push_orig_mask,
  output logic [PC_W-1:0]  top_rpc,
  output logic [PC_W-1:0]  top_pc,
  output logic [LANES-1:0] top_mask,
  output logic             empty,
  output logic             room2
);

  localparam int SP_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PC_W-1:0]  rpc;
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] mask;
  } ent_t;

  logic [SP_W-1:0] sp_q;
  ent_t            slot_q [DEPTH];
  ent_t            ent_lo;
  ent_t            ent_hi;
  ent_t            top;

  // Lower entry restores the pre-branch mask at the reconvergence PC,
  // upper entry starts the else path when the if path reaches it.
  assign ent_lo = '{rpc: push_rpc, pc: push_rpc,     mask: push_orig_mask};
  assign ent_hi = '{rpc: push_rpc, pc: push_else_pc, mask: push_else_mask};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ent_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push && sp_q == SP_W'(i)) begin
        q <= ent_lo;
      end else if (push && (sp_q + SP_W'(1)) == SP_W'(i)) begin
        q <= ent_hi;
      end
    end
    assign slot_q[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= '0;
    else if (push) sp_q <= sp_q + SP_W'(2);
    else if (pop)  sp_q <= sp_q - SP_W'(1);
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) top = slot_q[i];
    end
  end

  assign top_rpc  = top.rpc;
  assign top_pc   = top.pc;
  assign top_mask = top.mask;
  assign empty    = (sp_q == '0);
  assign room2    = (int'(sp_q) + 2 <= DEPTH);

  // R7: the pointer stays within the stack depth.
  a_r7_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp_q) <= DEPTH);
  // R7: a pop removes exactly one entry.
  a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> sp_q == $past(sp_q) - SP_W'(1));
  // R3: a split adds exactly two entries.
  a_r3_push_two: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + SP_W'(2));
  // R8: the owner never pushes into a stack without room.
  a_r8_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> room2);
  // R10: push and pop never coincide.
  a_r10_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  // R7: pop only from a stack with entries.
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/simt_diverge_unit.sv
module simt_diverge_unit
  import simt_div_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int PC_W    = 32,
  parameter int DEPTH   = 8,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fall,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] active_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             err_overflow
);

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] taken_lanes;
  logic [LANES-1:0] other_lanes;
  br_kind_e         kind;

  logic [PC_W-1:0]  top_rpc;
  logic [PC_W-1:0]  top_pc;
  logic [LANES-1:0] top_mask;
  logic             stk_empty;
  logic             stk_room2;

  // Named internal events for assertions.
  logic pop_hit;   // current PC reached the top entry's reconvergence PC
  logic br_live;   // branch event that is not overridden by a pop (R10)
  logic div_go;    // divergent branch with room: split the warp
  logic ovf_hit;   // divergent branch without room

  simt_lane_split #(.LANES(LANES)) u_split (
    .cond  (br_cond),
    .mask  (mask_q),
    .taken (taken_lanes),
    .other (other_lanes),
    .kind  (kind)
  );

  simt_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk            (clk),
    .rst_n          (rst_n),
    .push           (div_go),
    .pop            (pop_hit),
    .push_rpc       (br_reconv),
    .push_else_pc   (br_fall),
    .push_else_mask (other_lanes),
    .push_orig_mask (mask_q),
    .top_rpc        (top_rpc),
    .top_pc         (top_pc),
    .top_mask       (top_mask),
    .empty          (stk_empty),
    .room2          (stk_room2)
  );

  assign pop_hit = !stk_empty && (cur_pc == top_rpc);
  assign br_live = br_valid && !pop_hit;
  assign div_go  = br_live && (kind == BR_SPLIT) && stk_room2;
  assign ovf_hit = br_live && (kind == BR_SPLIT) && !stk_room2;

  always_comb begin
    if (pop_hit)                              next_pc = top_pc;
    else if (br_live && kind == BR_NONE_TAKEN) next_pc = br_fall;
    else if (br_live)                         next_pc = br_target;
    else                                      next_pc = cur_pc + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q       <= '1;
      err_overflow <= 1'b0;
    end else begin
      if (pop_hit)     mask_q <= top_mask;
      else if (div_go) mask_q <= taken_lanes;
      if (ovf_hit)     err_overflow <= 1'b1;
    end
  end

  assign active_mask = mask_q;

  // R3: the warp always keeps at least one live lane.
  a_r3_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);
  // R2: a uniform branch leaves the mask as it was.
  a_r2_uniform_hold: assert property (@(posedge clk) disable iff (!rst_n)
    br_live && kind != BR_SPLIT |=> active_mask == $past(active_mask));
  // R3: after a split, only live lanes with condition 1 stay on.
  a_r3_if_first: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |=> active_mask == ($past(br_cond) & $past(active_mask)));
  // R8: overflow keeps the mask and raises the flag.
  a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> active_mask == $past(active_mask) && err_overflow);
  // R8: the flag is sticky until reset.
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
  // R9: a quiet cycle keeps the mask.
  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid && !pop_hit |=> active_mask == $past(active_mask));

endmodule

// File: tb/simt_diverge_unit_bench.sv
module simt_diverge_unit_bench;

  localparam int CLK_P    = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_cond = '0;
  logic [31:0] br_target = '0;
  logic [31:0] br_fall = '0;
  logic [31:0] br_reconv = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] active_mask;
  logic [31:0] next_pc;
  logic        err_overflow;

  simt_diverge_unit u_simt_diverge_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .br_cond      (br_cond),
    .br_target    (br_target),
    .br_fall      (br_fall),
    .br_reconv    (br_reconv),
    .cur_pc       (cur_pc),
    .active_mask  (active_mask),
    .next_pc      (next_pc),
    .err_overflow (err_overflow)
  );

  always #(CLK_P / 2) clk = ~clk;

  typedef struct {
    logic [31:0] exp_pc;
    logic [31:0] exp_mask;
    logic        exp_err;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  int    cycles   = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus its expected outcome.
  task automatic step(input logic bv, input logic [31:0] cond, input logic [31:0] tgt,
                      input logic [31:0] fall, input logic [31:0] rec,
                      input logic [31:0] pc, input logic [31:0] e_pc,
                      input logic [31:0] e_mask, input logic e_err, input string tag);
    item_t it;
    @(negedge clk);
    br_valid  = bv;
    br_cond   = cond;
    br_target = tgt;
    br_fall   = fall;
    br_reconv = rec;
    cur_pc    = pc;
    it.exp_pc = e_pc; it.exp_mask = e_mask; it.exp_err = e_err; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input logic [31:0] pc, input logic [31:0] e_pc,
                      input logic [31:0] e_mask, input logic e_err, input string tag);
    step(1'b0, '0, '0, '0, '0, pc, e_pc, e_mask, e_err, tag);
  endtask

  // Monitor: next_pc before the edge, mask and flag after it.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P / 4);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got_pc;
        it = sb_q.pop_front();
        got_pc = next_pc;
        @(posedge clk);
        #1;
        check(got_pc == it.exp_pc, it.tag, "next_pc", got_pc, it.exp_pc);
        check(active_mask == it.exp_mask, it.tag, "active_mask", active_mask, it.exp_mask);
        check(err_overflow == it.exp_err, it.tag, "err_overflow",
              {31'b0, err_overflow}, {31'b0, it.exp_err});
      end
    end
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(active_mask == 32'hFFFF_FFFF, "R1", "reset mask", active_mask, 32'hFFFF_FFFF);
    check(err_overflow == 1'b0, "R1", "reset flag", {31'b0, err_overflow}, 32'h0);
    // R1 / R9: empty stack, plain step
    idle(32'h100, 32'h104, 32'hFFFF_FFFF, 1'b0, "R9");
    // R2: uniform taken and uniform not taken
    step(1'b1, 32'hFFFF_FFFF, 32'h200, 32'h108, 32'h300, 32'h104,
         32'h200, 32'hFFFF_FFFF, 1'b0, "R2");
    step(1'b1, 32'h0, 32'h200, 32'h108, 32'h300, 32'h104,
         32'h108, 32'hFFFF_FFFF, 1'b0, "R2");
    // R3: divergent branch, lower half taken
    step(1'b1, 32'h0000_FFFF, 32'h200, 32'h10C, 32'h300, 32'h108,
         32'h200, 32'h0000_FFFF, 1'b0, "R3");
    idle(32'h200, 32'h204, 32'h0000_FFFF, 1'b0, "R9");
    // R6: inactive lanes say taken, live lanes say not taken -> uniform fall-through
    step(1'b1, 32'hA5A5_0000, 32'h2F0, 32'h208, 32'h400, 32'h204,
         32'h208, 32'h0000_FFFF, 1'b0, "R6");
    // R4: if path reaches reconvergence -> else path
    idle(32'h300, 32'h10C, 32'hFFFF_0000, 1'b0, "R4");
    idle(32'h10C, 32'h110, 32'hFFFF_0000, 1'b0, "R9");
    // R5: else path reaches reconvergence -> full mask
    idle(32'h300, 32'h300, 32'hFFFF_FFFF, 1'b0, "R5");
    idle(32'h300, 32'h304, 32'hFFFF_FFFF, 1'b0, "R5");
    // R7: nested divergence unwinds last-in first-out
    step(1'b1, 32'h0000_00FF, 32'h500, 32'h404, 32'h600, 32'h400,
         32'h500, 32'h0000_00FF, 1'b0, "R7");
    step(1'b1, 32'hFFFF_000F, 32'h520, 32'h504, 32'h580, 32'h500,
         32'h520, 32'h0000_000F, 1'b0, "R7");
    idle(32'h580, 32'h504, 32'h0000_00F0, 1'b0, "R7");
    idle(32'h580, 32'h580, 32'h0000_00FF, 1'b0, "R7");
    idle(32'h600, 32'h404, 32'hFFFF_FF00, 1'b0, "R7");
    idle(32'h600, 32'h600, 32'hFFFF_FFFF, 1'b0, "R7");
    // R10: reconvergence match overrides a simultaneous branch
    step(1'b1, 32'h0000_0001, 32'h710, 32'h704, 32'h800, 32'h700,
         32'h710, 32'h0000_0001, 1'b0, "R10");
    step(1'b1, 32'hFFFF_FFFF, 32'h900, 32'h804, 32'hA00, 32'h800,
         32'h704, 32'hFFFF_FFFE, 1'b0, "R10");
    idle(32'h800, 32'h800, 32'hFFFF_FFFF, 1'b0, "R10");
    // R8: fill the stack with four splits, the fifth overflows
    step(1'b1, 32'h0000_FFFF, 32'h1100, 32'h1004, 32'h1F00, 32'h1000,
         32'h1100, 32'h0000_FFFF, 1'b0, "R8");
    step(1'b1, 32'h0000_00FF, 32'h1200, 32'h1104, 32'h1E00, 32'h1100,
         32'h1200, 32'h0000_00FF, 1'b0, "R8");
    step(1'b1, 32'h0000_000F, 32'h1300, 32'h1204, 32'h1D00, 32'h1200,
         32'h1300, 32'h0000_000F, 1'b0, "R8");
    step(1'b1, 32'h0000_0003, 32'h1400, 32'h1304, 32'h1C00, 32'h1300,
         32'h1400, 32'h0000_0003, 1'b0, "R8");
    step(1'b1, 32'h0000_0001, 32'h1500, 32'h1404, 32'h1B00, 32'h1400,
         32'h1500, 32'h0000_0003, 1'b1, "R8");
    idle(32'h1500, 32'h1504, 32'h0000_0003, 1'b1, "R8");
    // R8: stack untouched by the overflow: top is still the fourth split's else path
    idle(32'h1C00, 32'h1304, 32'h0000_000C, 1'b1, "R8");
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule